// File: doc/BRIEF.md
# Masked Multi-Lane Vector ALU

This block performs integer operations across one vector register's worth of elements. A vector holds `ELEMS` elements of `WIDTH` bits. The block handles `LANES` elements per clock, so one operation is issued over `ELEMS/LANES` consecutive beats. Beat k covers elements k·LANES up to k·LANES+LANES−1. Each beat then passes through a fixed pipeline of `BASE_LAT` stages before it is written into the result registers.

Two kinds of operation are supported. Arithmetic operations produce new element values: vector plus vector, and scalar plus vector. Compare operations produce a bit vector instead: signed greater-than between two vectors, equality against the scalar, and a bitwise AND of two bit vectors.

Every operation respects an active length. When masking is switched on, the destination's own bit vector also gates the update, for every operation except the bit-vector AND. The caller supplies the destination's current elements and bit vector. Every position that is not written comes back unchanged in the result.

A new operation is accepted while the previous one is in its last issue beat. Back-to-back operations therefore start every `ELEMS/LANES` cycles, and their pipelines overlap.

Top module: `mvalu_top`

## Requirements
- R1: With `op`=0, element i of `res_vec` becomes `src_a[i] + src_b[i]`, wrapping modulo 2^WIDTH. Element i occupies bits [i·WIDTH +: WIDTH] of every vector port.
- R2: With `op`=1, element i of `res_vec` becomes `scalar + src_b[i]`, wrapping modulo 2^WIDTH.
- R3: With `op`=2, bit i of `res_bits` becomes 1 exactly when `src_a[i]` is greater than `src_b[i]`, both read as signed two's complement. `res_vec` returns `dst_old`.
- R4: With `op`=3, bit i of `res_bits` becomes 1 exactly when `src_a[i]` equals `scalar`. `res_vec` returns `dst_old`.
- R5: With `op`=4, bit i of `res_bits` becomes `bits_a[i] & bits_b[i]`. `mask_en` has no effect on this operation, and `res_vec` returns `dst_old`.
- R6: When `mask_en`=1, operations 0 to 3 update only the positions i where `dst_bits[i]`=1. Every other position returns its `dst_old` element and its `dst_bits` bit.
- R7: Positions with index i ≥ `act_len` return `dst_old[i]` and `dst_bits[i]` for every operation. With `act_len` = 0 nothing changes. An `act_len` above `ELEMS` makes all positions active.
- R8: Operations 0 and 1 return `res_bits` equal to `dst_bits`. Operation codes 5, 6 and 7 return `dst_old` and `dst_bits` unchanged.
- R9: `start` is accepted on the rising edge where `busy` is 0. `done` is then high for one cycle after the (ELEMS/LANES + BASE_LAT)-th following edge, and the complete result is valid in that cycle.
- R10: `busy` is high for the ELEMS/LANES − 1 cycles after an accepting edge. A `start` seen while `busy` is high is ignored. Consequently, accepted operations are at least ELEMS/LANES cycles apart.
- R11: `res_vec` and `res_bits` hold their values once an operation has completed, until the writes of the next accepted operation begin.
- R12: Synchronous active-high `rst` clears `res_vec`, `res_bits`, `busy` and `done` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code (0 add, 1 scalar add, 2 signed greater-than, 3 equal to scalar, 4 bit AND) |
| src_a | input | ELEMS·WIDTH | First source vector |
| src_b | input | ELEMS·WIDTH | Second source vector |
| scalar | input | WIDTH | Scalar operand |
| act_len | input | clog2(ELEMS+1) | Number of active elements |
| mask_en | input | 1 | Enables masking by the destination bit vector |
| dst_old | input | ELEMS·WIDTH | Current destination elements |
| dst_bits | input | ELEMS | Current destination bit vector, which also serves as the mask |
| bits_a | input | ELEMS | First source bit vector for the AND |
| bits_b | input | ELEMS | Second source bit vector for the AND |
| res_vec | output | ELEMS·WIDTH | Resulting destination elements |
| res_bits | output | ELEMS | Resulting destination bit vector |
| busy | output | 1 | High while a new `start` would be ignored |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ELEMS=16, LANES=4, WIDTH=32 and BASE_LAT=3. This gives four issue beats and a seven-cycle operation latency.

With four beats, an active length of 5 stops partway through the second lane group, so the boundary between lane groups is exercised. A start held high through the busy window shows that the second operation is accepted on the fourth edge. It also shows that the two overlapping pipelines finish in order.

The 5-bit length port reaches values above 16, so the out-of-range active-length case can be checked. Element values drawn from a narrow range make equalities and signed boundary crossings frequent.

// File: rtl/mvalu_pkg.sv
package mvalu_pkg;

    typedef enum logic [2:0] {
        OP_VADD = 3'd0,
        OP_SADD = 3'd1,
        OP_GT   = 3'd2,
        OP_EQS  = 3'd3,
        OP_BAND = 3'd4,
        OP_RS5  = 3'd5,
        OP_RS6  = 3'd6,
        OP_RS7  = 3'd7
    } alu_op_e;

    // Operation classes used by the lanes
    function automatic logic op_writes_elem(alu_op_e op);
        return (op == OP_VADD) || (op == OP_SADD);
    endfunction

    function automatic logic op_writes_bit(alu_op_e op);
        return (op == OP_GT) || (op == OP_EQS) || (op == OP_BAND);
    endfunction

    function automatic logic op_obeys_mask(alu_op_e op);
        return op != OP_BAND;
    endfunction

    function automatic int unsigned beat_count(int unsigned elems, int unsigned lanes);
        return elems / lanes;
    endfunction

    function automatic int unsigned idx_width(int unsigned beats);
        return (beats > 1) ? $clog2(beats) : 1;
    endfunction

endpackage

// File: rtl/mvalu_issue.sv
module mvalu_issue
    import mvalu_pkg::*;
#(
    parameter int ELEMS = 32,
    parameter int LANES = 4,
    parameter int WIDTH = 32,
    parameter int LEN_W = 6,
    parameter int IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  alu_op_e                  op_in,
    input  logic [ELEMS*WIDTH-1:0]   a_in,
    input  logic [ELEMS*WIDTH-1:0]   b_in,
    input  logic [WIDTH-1:0]         scalar_in,
    input  logic [LEN_W-1:0]         len_in,
    input  logic                     men_in,
    input  logic [ELEMS*WIDTH-1:0]   old_in,
    input  logic [ELEMS-1:0]         dbits_in,
    input  logic [ELEMS-1:0]         ba_in,
    input  logic [ELEMS-1:0]         bb_in,
    output logic                     busy,
    output logic                     grp_valid,
    output logic                     grp_last,
    output logic [IDX_W-1:0]         grp_idx,
    output alu_op_e                  op_q,
    output logic [WIDTH-1:0]         scalar_q,
    output logic [LEN_W-1:0]         len_q,
    output logic                     men_q,
    output logic [LANES*WIDTH-1:0]   grp_a,
    output logic [LANES*WIDTH-1:0]   grp_b,
    output logic [LANES*WIDTH-1:0]   grp_old,
    output logic [LANES-1:0]         grp_dbits,
    output logic [LANES-1:0]         grp_ba,
    output logic [LANES-1:0]         grp_bb
);
    localparam int BEATS = beat_count(ELEMS, LANES);
    localparam int GW    = LANES * WIDTH;
    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BEATS - 1);

    logic                   active;
    logic [IDX_W-1:0]       beat;
    logic                   accept;
    logic [ELEMS*WIDTH-1:0] a_q, b_q, old_q;
    logic [ELEMS-1:0]       dbits_q, ba_q, bb_q;

    assign grp_last  = active && (beat == LAST_BEAT);
    assign busy      = active && !grp_last;
    assign accept    = start && !busy;
    assign grp_valid = active;
    assign grp_idx   = beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (accept) begin
            active <= 1'b1;
            beat   <= '0;
        end else if (active) begin
            if (grp_last) active <= 1'b0;
            else          beat   <= beat + 1'b1;
        end
    end

    // Operands are captured once per operation and sliced per beat
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_RS7;
            scalar_q <= '0;
            len_q    <= '0;
            men_q    <= 1'b0;
            a_q      <= '0;
            b_q      <= '0;
            old_q    <= '0;
            dbits_q  <= '0;
            ba_q     <= '0;
            bb_q     <= '0;
        end else if (accept) begin
            op_q     <= op_in;
            scalar_q <= scalar_in;
            len_q    <= len_in;
            men_q    <= men_in;
            a_q      <= a_in;
            b_q      <= b_in;
            old_q    <= old_in;
            dbits_q  <= dbits_in;
            ba_q     <= ba_in;
            bb_q     <= bb_in;
        end
    end

    assign grp_a     = a_q[int'(beat)*GW +: GW];
    assign grp_b     = b_q[int'(beat)*GW +: GW];
    assign grp_old   = old_q[int'(beat)*GW +: GW];
    assign grp_dbits = dbits_q[int'(beat)*LANES +: LANES];
    assign grp_ba    = ba_q[int'(beat)*LANES +: LANES];
    assign grp_bb    = bb_q[int'(beat)*LANES +: LANES];

endmodule

// File: rtl/mvalu_lane.sv
module mvalu_lane
    import mvalu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int LEN_W = 6
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic [WIDTH-1:0]   scalar,
    input  logic [WIDTH-1:0]   old_elem,
    input  logic               old_bit,
    input  logic               ba,
    input  logic               bb,
    input  logic               men,
    input  logic [LEN_W-1:0]   elem_idx,
    input  logic [LEN_W-1:0]   len,
    output logic [WIDTH-1:0]   out_elem,
    output logic               out_bit
);
    logic             in_range;
    logic             allow;
    logic [WIDTH-1:0] new_elem;
    logic             new_bit;

    assign in_range = elem_idx < len;
    // The destination bit vector doubles as the write mask
    assign allow    = in_range && (!(men && op_obeys_mask(op)) || old_bit);

    always_comb begin
        new_elem = old_elem;
        new_bit  = old_bit;
        unique case (op)
            OP_VADD: new_elem = a + b;
            OP_SADD: new_elem = scalar + b;
            OP_GT:   new_bit  = $signed(a) > $signed(b);
            OP_EQS:  new_bit  = (a == scalar);
            OP_BAND: new_bit  = ba & bb;
            default: ;
        endcase
    end

    assign out_elem = (allow && op_writes_elem(op)) ? new_elem : old_elem;
    assign out_bit  = (allow && op_writes_bit(op))  ? new_bit  : old_bit;

endmodule

// File: rtl/mvalu_pipe.sv
module mvalu_pipe #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic [DEPTH-1:0] vld;
    logic [DW-1:0]    dat [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= in_valid;
        dat[0] <= in_data;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) vld[s] <= 1'b0;
            else     vld[s] <= vld[s-1];
            dat[s] <= dat[s-1];
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];

endmodule

// File: rtl/mvalu_wb.sv
module mvalu_wb #(
    parameter int ELEMS = 32,
    parameter int LANES = 4,
    parameter int WIDTH = 32,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_last,
    input  logic [IDX_W-1:0]       in_idx,
    input  logic [LANES*WIDTH-1:0] in_elems,
    input  logic [LANES-1:0]       in_bits,
    output logic [ELEMS*WIDTH-1:0] res_vec,
    output logic [ELEMS-1:0]       res_bits,
    output logic                   done
);
    localparam int GW = LANES * WIDTH;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vec  <= '0;
            res_bits <= '0;
            done     <= 1'b0;
        end else begin
            done <= in_valid && in_last;
            if (in_valid) begin
                res_vec[int'(in_idx)*GW +: GW]        <= in_elems;
                res_bits[int'(in_idx)*LANES +: LANES] <= in_bits;
            end
        end
    end

endmodule

// File: rtl/mvalu_top.sv
module mvalu_top
    import mvalu_pkg::*;
#(
    parameter int ELEMS    = 32,
    parameter int LANES    = 4,
    parameter int WIDTH    = 32,
    parameter int BASE_LAT = 2,
    localparam int LEN_W   = $clog2(ELEMS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [2:0]             op,
    input  logic [ELEMS*WIDTH-1:0] src_a,
    input  logic [ELEMS*WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0]       scalar,
    input  logic [LEN_W-1:0]       act_len,
    input  logic                   mask_en,
    input  logic [ELEMS*WIDTH-1:0] dst_old,
    input  logic [ELEMS-1:0]       dst_bits,
    input  logic [ELEMS-1:0]       bits_a,
    input  logic [ELEMS-1:0]       bits_b,
    output logic [ELEMS*WIDTH-1:0] res_vec,
    output logic [ELEMS-1:0]       res_bits,
    output logic                   busy,
    output logic                   done
);
    localparam int BEATS = beat_count(ELEMS, LANES);
    localparam int IDX_W = idx_width(BEATS);
    localparam int GW    = LANES * WIDTH;
    localparam int DW    = 1 + IDX_W + GW + LANES;

    logic                 grp_valid, grp_last;
    logic [IDX_W-1:0]     grp_idx;
    alu_op_e              op_q;
    logic [WIDTH-1:0]     scalar_q;
    logic [LEN_W-1:0]     len_q;
    logic                 men_q;
    logic [GW-1:0]        grp_a, grp_b, grp_old;
    logic [LANES-1:0]     grp_dbits, grp_ba, grp_bb;
    logic [GW-1:0]        lane_elems;
    logic [LANES-1:0]     lane_bits;
    logic                 wb_valid;
    logic [DW-1:0]        wb_data;

    mvalu_issue #(
        .ELEMS(ELEMS), .LANES(LANES), .WIDTH(WIDTH), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_issue (
        .clk(clk), .rst(rst), .start(start), .op_in(alu_op_e'(op)),
        .a_in(src_a), .b_in(src_b), .scalar_in(scalar), .len_in(act_len),
        .men_in(mask_en), .old_in(dst_old), .dbits_in(dst_bits),
        .ba_in(bits_a), .bb_in(bits_b),
        .busy(busy), .grp_valid(grp_valid), .grp_last(grp_last), .grp_idx(grp_idx),
        .op_q(op_q), .scalar_q(scalar_q), .len_q(len_q), .men_q(men_q),
        .grp_a(grp_a), .grp_b(grp_b), .grp_old(grp_old),
        .grp_dbits(grp_dbits), .grp_ba(grp_ba), .grp_bb(grp_bb)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LEN_W-1:0] eidx;
        assign eidx = LEN_W'(int'(grp_idx) * LANES + l);

        mvalu_lane #(.WIDTH(WIDTH), .LEN_W(LEN_W)) u_lane (
            .op(op_q),
            .a(grp_a[l*WIDTH +: WIDTH]),
            .b(grp_b[l*WIDTH +: WIDTH]),
            .scalar(scalar_q),
            .old_elem(grp_old[l*WIDTH +: WIDTH]),
            .old_bit(grp_dbits[l]),
            .ba(grp_ba[l]),
            .bb(grp_bb[l]),
            .men(men_q),
            .elem_idx(eidx),
            .len(len_q),
            .out_elem(lane_elems[l*WIDTH +: WIDTH]),
            .out_bit(lane_bits[l])
        );
    end

    mvalu_pipe #(.DW(DW), .DEPTH(BASE_LAT)) u_pipe (
        .clk(clk), .rst(rst),
        .in_valid(grp_valid),
        .in_data({grp_last, grp_idx, lane_elems, lane_bits}),
        .out_valid(wb_valid),
        .out_data(wb_data)
    );

    mvalu_wb #(
        .ELEMS(ELEMS), .LANES(LANES), .WIDTH(WIDTH), .IDX_W(IDX_W)
    ) u_wb (
        .clk(clk), .rst(rst),
        .in_valid(wb_valid),
        .in_last(wb_data[DW-1]),
        .in_idx(wb_data[DW-2 -: IDX_W]),
        .in_elems(wb_data[LANES +: GW]),
        .in_bits(wb_data[LANES-1:0]),
        .res_vec(res_vec), .res_bits(res_bits), .done(done)
    );

endmodule

// File: rtl/mvalu_chk.sv
module mvalu_chk #(
    parameter int ELEMS    = 32,
    parameter int LANES    = 4,
    parameter int WIDTH    = 32,
    parameter int BASE_LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   busy,
    input  logic                   done,
    input  logic [ELEMS*WIDTH-1:0] res_vec,
    input  logic [ELEMS-1:0]       res_bits
);
    localparam int BEATS = ELEMS / LANES;
    localparam int LAT   = BEATS + BASE_LAT;
    localparam int SW    = $clog2(BEATS + 1);

    logic           accept;
    logic [LAT-1:0] hist;
    logic [SW-1:0]  since;
    logic           seen;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            since <= '0;
            seen  <= 1'b0;
        end else begin
            hist <= {hist[LAT-2:0], accept};
            if (accept) begin
                since <= '0;
                seen  <= 1'b1;
            end else if (since < SW'(BEATS)) begin
                since <= since + 1'b1;
            end
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        hist[LAT-1] |=> done);                                          // R9
    AST_DONE_ONLY_DUE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(hist[LAT-1]));                                   // R9
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        busy == (seen && (since < SW'(BEATS - 1))));                   // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hist == '0) |=> ($stable(res_vec) && $stable(res_bits)));      // R11
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!done && !busy && res_vec == '0 && res_bits == '0));   // R12

endmodule

bind mvalu_top mvalu_chk #(
    .ELEMS(ELEMS), .LANES(LANES), .WIDTH(WIDTH), .BASE_LAT(BASE_LAT)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .res_vec(res_vec), .res_bits(res_bits)
);

// File: tb/sim_mvalu_top.sv
module sim_mvalu_top;
    localparam int E     = 16;
    localparam int L     = 4;
    localparam int W     = 32;
    localparam int BL    = 3;
    localparam int BEATS = E / L;
    localparam int LAT   = BEATS + BL;
    localparam int VW    = E * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op = '0;
    logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [W-1:0]  scalar = '0;
    logic [4:0]    act_len = '0;
    logic          mask_en = 1'b0;
    logic [E-1:0]  dst_bits = '0, bits_a = '0, bits_b = '0;
    logic [VW-1:0] res_vec;
    logic [E-1:0]  res_bits, busy_unused;
    logic          busy, done;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mvalu_top #(.ELEMS(E), .LANES(L), .WIDTH(W), .BASE_LAT(BL)) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .scalar(scalar), .act_len(act_len),
        .mask_en(mask_en), .dst_old(dst_old), .dst_bits(dst_bits),
        .bits_a(bits_a), .bits_b(bits_b),
        .res_vec(res_vec), .res_bits(res_bits), .busy(busy), .done(done)
    );

    assign busy_unused = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent reference of the requirements R1..R8
    function automatic void model(output logic [VW-1:0] ev, output logic [E-1:0] eb);
        ev = dst_old;
        eb = dst_bits;
        for (int i = 0; i < E; i++) begin
            logic [W-1:0] ai, bi;
            bit in_r, ok;
            ai   = src_a[i*W +: W];
            bi   = src_b[i*W +: W];
            in_r = i < int'(act_len);
            ok   = in_r && (!mask_en || dst_bits[i]);
            case (op)
                3'd0: if (ok) ev[i*W +: W] = ai + bi;
                3'd1: if (ok) ev[i*W +: W] = scalar + bi;
                3'd2: if (ok) eb[i] = ($signed(ai) > $signed(bi));
                3'd3: if (ok) eb[i] = (ai == scalar);
                3'd4: if (in_r) eb[i] = bits_a[i] & bits_b[i];
                default: ;
            endcase
        end
    endfunction

    task automatic fill_rand(input bit narrow);
        for (int i = 0; i < E; i++) begin
            src_a[i*W +: W]   = narrow ? W'($urandom_range(0, 3)) - 32'd1 : $urandom;
            src_b[i*W +: W]   = narrow ? W'($urandom_range(0, 3)) - 32'd1 : $urandom;
            dst_old[i*W +: W] = $urandom;
        end
        scalar   = narrow ? W'($urandom_range(0, 2)) : $urandom;
        dst_bits = E'($urandom);
        bits_a   = E'($urandom);
        bits_b   = E'($urandom);
    endtask

    task automatic run_one(input string req);
        logic [VW-1:0] ev;
        logic [E-1:0]  eb;
        bit early;
        model(ev, eb);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", VW'(busy), VW'(1));
        early = 0;
        for (int t = 0; t < LAT; t++) begin
            if (done) early = 1;
            @(negedge clk);
        end
        chk(done && !early, "R9", "done timing", VW'({early, done}), VW'(1));
        chk(res_vec == ev, req, "res_vec", res_vec, ev);
        chk(res_bits == eb, req, "res_bits", VW'(res_bits), VW'(eb));
        @(negedge clk);
        chk(!done && res_vec == ev && res_bits == eb, "R11", "hold after done",
            VW'(done), VW'(0));
    endtask

    task automatic busy_test();
        logic [VW-1:0] eva, evb;
        logic [E-1:0]  eba, ebb;
        bit bad_done;
        op = 3'd0; fill_rand(0); act_len = 5'd16; mask_en = 1'b0;
        model(eva, eba);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op = 3'd3; fill_rand(1); act_len = 5'd10; mask_en = 1'b1;
        model(evb, ebb);
        bad_done = 0;
        for (int t = 0; t <= BEATS + LAT; t++) begin
            if (t < BEATS)
                chk(busy == (t < BEATS - 1), "R10", "busy window",
                    VW'(busy), VW'(t < BEATS - 1));
            if (t == BEATS) start = 1'b0;
            if (t == LAT) begin
                chk(done == 1'b1, "R9", "first done", VW'(done), VW'(1));
                chk(res_vec == eva, "R1", "first result", res_vec, eva);
            end else if (t == BEATS + LAT) begin
                chk(done == 1'b1, "R10", "second accepted at beat boundary", VW'(done), VW'(1));
                chk(res_vec == evb && res_bits == ebb, "R4", "second result",
                    VW'(res_bits), VW'(ebb));
            end else if (done) begin
                bad_done = 1;
            end
            @(negedge clk);
        end
        chk(!bad_done, "R10", "no extra done from ignored start", VW'(bad_done), VW'(0));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(res_vec == '0 && res_bits == '0, "R12", "reset results", res_vec, '0);
        chk(!busy && !done, "R12", "reset flags", VW'({busy, done}), VW'(0));

        // R1 with wrap in element 0
        fill_rand(0); op = 3'd0; act_len = 5'd16; mask_en = 1'b0;
        src_a[0 +: W] = 32'hFFFF_FFFF; src_b[0 +: W] = 32'd2;
        run_one("R1");
        // R2 with a negative scalar
        fill_rand(0); op = 3'd1; scalar = 32'hFFFF_FFF0;
        run_one("R2");
        // R3 signed corners
        fill_rand(1); op = 3'd2;
        src_a[0 +: W] = 32'hFFFF_FFFF; src_b[0 +: W] = 32'd1;
        src_a[W +: W] = 32'd1;         src_b[W +: W] = 32'hFFFF_FFFF;
        src_a[2*W +: W] = 32'h8000_0000; src_b[2*W +: W] = 32'h7FFF_FFFF;
        run_one("R3");
        // R4
        fill_rand(1); op = 3'd3;
        run_one("R4");
        // R5 ignores mask even with an all-zero mask
        fill_rand(0); op = 3'd4; mask_en = 1'b1; dst_bits = '0;
        run_one("R5");
        // R6 masking on arithmetic and compare
        fill_rand(0); op = 3'd0; mask_en = 1'b1; dst_bits = 16'hA5C3;
        run_one("R6");
        fill_rand(1); op = 3'd2; mask_en = 1'b1; dst_bits = 16'h0FF0;
        run_one("R6");
        // R7 length within a lane group, zero and beyond ELEMS
        fill_rand(0); op = 3'd1; mask_en = 1'b0; act_len = 5'd5;
        run_one("R7");
        fill_rand(1); op = 3'd2; act_len = 5'd0;
        run_one("R7");
        fill_rand(0); op = 3'd0; act_len = 5'd20;
        run_one("R7");
        // R8 reserved code and bit vector passthrough
        fill_rand(0); op = 3'd6; act_len = 5'd16;
        run_one("R8");
        fill_rand(0); op = 3'd1; mask_en = 1'b1;
        run_one("R8");
        // R10 busy window with a held start
        busy_test();
        // Random mix
        for (int k = 0; k < 40; k++) begin
            fill_rand(k[0]);
            op      = 3'($urandom_range(0, 5));
            act_len = 5'($urandom_range(0, 18));
            mask_en = 1'($urandom);
            run_one(op == 3'd0 ? "R1" : op == 3'd1 ? "R2" : op == 3'd2 ? "R3" :
                    op == 3'd3 ? "R4" : op == 3'd4 ? "R5" : "R8");
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule